// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block supplies the address for each transfer of a four-transfer burst. When a burst begins it captures a full external address. From that point the upper bits stay fixed, and the two low bits walk through four positions. The walk order is set by a slowly changing mode input. One order combines the starting lane with the beat count by exclusive-or. The other adds the beat count to the starting lane, modulo four.

The surrounding command decode tells the block when to start and when to step. It asserts the load input on either kind of burst start. It asserts the advance input on a continue cycle. A cycle with neither input asserted is a suspend, and the address is held. After the fourth beat, one more advance returns to the first address of the sequence. The carry never reaches the upper bits. The mode input is registered, so a change of mode is reflected in the address one clock later.

Top module: `burst_addr_gen`

## Requirements
- R1: While synchronous active-low reset is applied, and after it, with no load or advance, the address output is all zeros, the beat index is 0 and the registered mode is linear (0).
- R2: A clock edge with load asserted makes the address output equal to the load address and sets the beat index to 0.
- R3: With registered mode 1 (interleaved), the low two address bits equal start_lane XOR beat.
- R4: With registered mode 0 (linear), the low two address bits equal (start_lane + beat) mod 4.
- R5: A clock edge with advance asserted and load deasserted increments the beat index by one.
- R6: A clock edge with neither load nor advance asserted leaves the address output and the beat index unchanged.
- R7: An advance from beat 3 returns the beat index to 0 and the address to its value at load, with no carry into bit 2 or above.
- R8: The address bits from bit 2 upward change only on a clock edge with load asserted. The load-address input is ignored otherwise.
- R9: When load and advance are asserted on the same edge, load wins: beat index 0 and the new load address.
- R10: A change on the mode input leaves the current address unchanged until the next clock edge. From that edge on, the address follows the new order at the same beat index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Burst start: capture addr_i |
| adv_i | input | 1 | Step to the next beat |
| mode_i | input | 1 | Order select: 1 interleaved, 0 linear |
| addr_i | input | ADDR_W | Burst start address |
| addr_o | output | ADDR_W | Address of the current beat |
| beat_o | output | 2 | Beats advanced since load, modulo 4 |

## Verification
The main sweep loads every starting lane under both orders, with several upper-bit patterns. Each burst then advances five times, so the wrap back to the first address is seen. A suspend cycle is placed in the middle of each burst. Lanes 01 and 11 are where the two orders differ, so those starts tell the orders apart. Garbage on the address input during advance and suspend cycles shows that the upper bits are locked. Two further cases are tried. One drives load and advance on the same edge. The other flips the mode mid-burst and samples before and after the next edge, which shows the one-cycle latency.

// File: rtl/burst_pkg.sv
// Package: shared types and the lane-order function for the burst sequencer.
// Assumes a four-beat burst, so the lane is two bits wide.
package burst_pkg;
    localparam int LANE_W = 2;
    typedef logic [LANE_W-1:0] lane_t;

    // Map a start lane and beat count to the lane of the current beat.
    function automatic lane_t burst_lane(input lane_t start, input lane_t beat,
                                         input logic interleave);
        lane_t r;
        if (interleave) r = start ^ beat;
        else            r = start + beat;   // wraps modulo 4 by width
        return r;
    endfunction
endpackage

// File: rtl/burst_mode_reg.sv
// Module: registers the static order-select input.
// Assumes the mode changes rarely; adds one cycle of latency to a change.
module burst_mode_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_i,
    output logic mode_q
);
    // Capture the order select each cycle; reset to linear.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= mode_i;
    end
endmodule

// File: rtl/burst_beat_ctr.sv
// Module: two-bit beat counter for a four-beat burst.
// Assumes load has priority over advance; the counter wraps naturally.
module burst_beat_ctr
    import burst_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  logic  adv_i,
    output lane_t beat_q
);
    // Clear on load, step on advance, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      beat_q <= '0;
        else if (load_i) beat_q <= '0;
        else if (adv_i)  beat_q <= beat_q + lane_t'(1);
    end

    // R2, R9
    load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> beat_q == '0);
    // R5
    adv_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i) |=> beat_q == lane_t'($past(beat_q) + lane_t'(1)));
    // R6
    suspend_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !load_i) |=> $stable(beat_q));
    // R7
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && beat_q == 2'd3) |=> beat_q == '0);
endmodule

// File: rtl/burst_base_reg.sv
// Module: holds the burst start address captured on load.
// Assumes the start address input is meaningful only when load is asserted.
module burst_base_reg #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] base_q
);
    // Capture the start address on load only.
    always_ff @(posedge clk) begin
        if (!rst_n)      base_q <= '0;
        else if (load_i) base_q <= addr_i;
    end

    // R2
    base_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> base_q == $past(addr_i));
    // R8
    base_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(base_q));
endmodule

// File: rtl/burst_addr_gen.sv
// Module: top of the four-beat burst address sequencer.
// Combines the captured start address, the beat count and the registered
// mode into the current address. Assumes ADDR_W > 2.
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic              mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        beat_o
);
    localparam int UP_W = ADDR_W - LANE_W;

    logic              mode_q;
    lane_t             beat_q;
    logic [ADDR_W-1:0] base_q;
    lane_t             lane;

    burst_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode_i),
        .mode_q (mode_q)
    );

    burst_beat_ctr u_beat (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .adv_i  (adv_i),
        .beat_q (beat_q)
    );

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .addr_i (addr_i),
        .base_q (base_q)
    );

    // Select the lane of the current beat in the registered order.
    always_comb lane = burst_lane(base_q[LANE_W-1:0], beat_q, mode_q);

    // Drive the outputs: fixed upper part plus the sequenced lane.
    always_comb begin
        addr_o = {base_q[ADDR_W-1:LANE_W], lane};
        beat_o = beat_q;
    end

    // R8
    upper_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> addr_o[ADDR_W-1:LANE_W] == $past(addr_o[ADDR_W-1:LANE_W]));
    // R7
    wrap_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && beat_o == 2'd3 && mode_q == mode_i)
        |=> addr_o[LANE_W-1:0] == $past(base_q[LANE_W-1:0]));
    // R6
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !load_i && mode_q == mode_i) |=> $stable(addr_o));

    initial begin
        // Build-time sanity: upper part must exist.
        assert (UP_W > 0);
    end
endmodule

// File: tb/burst_addr_gen_tb.sv
// Bench: sweeps both orders, every start lane and several upper patterns.
module burst_addr_gen_tb_top;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic          adv_i = 1'b0;
    logic          mode_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] addr_o;
    logic [1:0]    beat_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [AW-1:0] ref_base = '0;
    logic [1:0]    ref_beat = '0;
    logic          ref_mode = 1'b0;

    burst_addr_gen #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_i(adv_i),
        .mode_i(mode_i), .addr_i(addr_i), .addr_o(addr_o), .beat_o(beat_o)
    );

    always #4 clk = ~clk;   // 125 MHz

    function automatic logic [AW-1:0] exp_addr();
        logic [1:0] ln;
        if (ref_mode) ln = ref_base[1:0] ^ ref_beat;
        else          ln = 2'((ref_base[1:0] + ref_beat) % 4);
        return {ref_base[AW-1:2], ln};
    endfunction

    task automatic check(input string tag, input logic [AW-1:0] act,
                         input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic ld, input logic av,
                         input logic [AW-1:0] a, input logic md);
        @(negedge clk);
        load_i = ld; adv_i = av; addr_i = a; mode_i = md;
        @(posedge clk);
        if (ld)      begin ref_base = a; ref_beat = 2'd0; end
        else if (av) ref_beat = ref_beat + 2'd1;
        ref_mode = md;
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        logic [AW-1:0] prev_up;
        repeat (3) @(posedge clk);
        #2;
        check("R1 addr in reset", addr_o, '0);
        check("R1 beat in reset", AW'(beat_o), '0);
        @(negedge clk); rst_n = 1'b1;
        cycle(1'b0, 1'b0, 8'hFF, 1'b0);
        check("R1 addr after reset", addr_o, '0);

        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int u = 0; u < 3; u++) begin
                    logic [AW-1:0] st;
                    st = {6'((u * 23 + 5) % 64), 2'(s)};
                    cycle(1'b1, 1'b0, st, 1'(m));
                    check("R2 load addr", addr_o, st);
                    check("R2 load beat", AW'(beat_o), '0);
                    for (int k = 1; k <= 5; k++) begin
                        if (k == 3) begin
                            prev_up = addr_o;
                            cycle(1'b0, 1'b0, ~st, 1'(m));
                            check("R6 suspend", addr_o, prev_up);
                        end
                        cycle(1'b0, 1'b1, st ^ 8'hA4, 1'(m));
                        check("R5 beat", AW'(beat_o), AW'(ref_beat));
                        if (k == 4)
                            check("R7 wrap home", addr_o, st);
                        else if (m == 1)
                            check("R3 interleaved", addr_o, exp_addr());
                        else
                            check("R4 linear", addr_o, exp_addr());
                        check("R8 upper", {addr_o[AW-1:2], 2'b00},
                              {st[AW-1:2], 2'b00});
                    end
                end
            end
        end

        // R9: load and advance on the same edge
        cycle(1'b1, 1'b0, 8'h31, 1'b0);
        cycle(1'b0, 1'b1, 8'h00, 1'b0);
        cycle(1'b1, 1'b1, 8'hC6, 1'b0);
        check("R9 load wins addr", addr_o, 8'hC6);
        check("R9 load wins beat", AW'(beat_o), '0);

        // R10: mode latency mid-burst (start lane 01, beat 1)
        cycle(1'b1, 1'b0, 8'h55, 1'b0);
        cycle(1'b0, 1'b1, 8'h00, 1'b0);
        check("R10 linear before flip", addr_o, 8'h56);
        @(negedge clk);
        load_i = 1'b0; adv_i = 1'b0; mode_i = 1'b1;
        #2;
        check("R10 unchanged before edge", addr_o, 8'h56);
        @(posedge clk); ref_mode = 1'b1; #2;
        check("R10 new order after edge", addr_o, 8'h54);
        check("R10 beat kept", AW'(beat_o), 8'h01);

        finish_run();
    end

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end
endmodule